// File: doc/BRIEF.md
# Dual-Read Register Bank with Hardwired Constants

This block is the register storage of a small microprogrammed accumulator machine. It offers sixteen 16-bit slots behind a single 4-bit address space. Eight slots are real registers that the datapath writes from its result bus. Five slots return fixed constants that the microcode uses for clearing, incrementing, decrementing and masking. The last three slots are unused.

Two independent combinational read ports select any slot. Each port feeds its own holding latch, which captures on its own load strobe. The latches are what the ALU side sees. One synchronous write port stores the result-bus word into the addressed slot when write enable is high.

A latch load and a write to the same slot on the same clock edge return the value held before that edge. Writes aimed at constant or unused slots are dropped.

Top module: `dual_read_regbank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every writable register and both latches become 0x0000 after that edge.
- R2: With `wr_en` high, the word on `wr_data` is stored at the rising edge into the slot `wr_sel`. The writable slots are at addresses 0, 1, 2, 3, 4, 10, 11 and 12. A later latch load from that slot returns the stored word.
- R3: The constant slots read as fixed values: 5 gives 0x0000, 6 gives 0x0001, 7 gives 0xFFFF, 8 gives the 12-bit address mask 0x0FFF, and 9 gives the 8-bit offset mask 0x00FF.
- R4: A write to any constant slot (addresses 5 to 9) is ignored, and the slot keeps its fixed value.
- R5: The unused slots (addresses 13 to 15) always read 0x0000, and writes to them change no slot.
- R6: A latch whose load strobe is low keeps its value across the edge, whatever its select input is.
- R7: When a latch loads from a slot that is written at the same edge, it captures the value held before that edge.
- R8: When both ports load from the same slot at the same edge, both latches hold the same value.
- R9: With `wr_en` low, no register changes, whatever `wr_sel` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 4 | Slot read by the A port |
| b_sel | input | 4 | Slot read by the B port |
| a_ld | input | 1 | Load strobe of the A latch |
| b_ld | input | 1 | Load strobe of the B latch |
| wr_sel | input | 4 | Slot written from the result bus |
| wr_data | input | 16 | Result-bus write data |
| wr_en | input | 1 | Write enable |
| a_latch | output | 16 | A latch contents |
| b_latch | output | 16 | B latch contents |

## Verification
The only path to the registers is through the latches, and a latch loads on the same edge as a write. The hardest case is therefore to show that a latch picks up the old word while the register takes the new one. The stimulus first writes a known word to a slot. On one edge it then writes a different word to that slot and loads both latches from it, and on the next edge it reloads one latch. The captured value must step from the old word to the new one across those two edges. Ignored writes to constant and unused slots are checked in the same way: each such write is followed at once by a load from the targeted slot.

// File: rtl/rb_pkg.sv
package rb_pkg;

   typedef enum logic [3:0] {
      SL_PC    = 4'd0,
      SL_AC    = 4'd1,
      SL_SP    = 4'd2,
      SL_IR    = 4'd3,
      SL_TIR   = 4'd4,
      SL_ZERO  = 4'd5,
      SL_ONE   = 4'd6,
      SL_MINUS = 4'd7,
      SL_AMSK  = 4'd8,
      SL_SMSK  = 4'd9,
      SL_GA    = 4'd10,
      SL_GB    = 4'd11,
      SL_GC    = 4'd12,
      SL_U13   = 4'd13,
      SL_U14   = 4'd14,
      SL_U15   = 4'd15
   } slot_e;

   localparam int unsigned SLOT_BITS = 4;
   localparam int unsigned NUM_WR    = 8;
   localparam int unsigned WR_IDX_W  = $clog2(NUM_WR);

   function automatic logic is_writable(input logic [SLOT_BITS-1:0] s);
      return (s <= 4'd4) || ((s >= 4'd10) && (s <= 4'd12));
   endfunction

   function automatic logic is_const(input logic [SLOT_BITS-1:0] s);
      return (s >= 4'd5) && (s <= 4'd9);
   endfunction

   // slots 0..4 map to storage 0..4, slots 10..12 map to storage 5..7
   function automatic logic [WR_IDX_W-1:0] wr_index(input logic [SLOT_BITS-1:0] s);
      logic [SLOT_BITS-1:0] t;
      t = (s <= 4'd4) ? s : s - 4'd5;
      return t[WR_IDX_W-1:0];
   endfunction

endpackage

// File: rtl/rb_store.sv
module rb_store
   import rb_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [SLOT_BITS-1:0]             sel,
   input  logic [DATA_W-1:0]                din,
   output logic [NUM_WR-1:0][DATA_W-1:0]    regs_q
);

   logic [NUM_WR-1:0] hit;

   always_comb begin
      hit = '0;
      if (we && is_writable(sel)) hit[wr_index(sel)] = 1'b1;
   end

   for (genvar gi = 0; gi < NUM_WR; gi++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)          regs_q[gi] <= '0;
         else if (hit[gi]) regs_q[gi] <= din;
      end
   end

   // R4 R5
   property p_nonwritable_ignored;
      @(posedge clk) disable iff (rst)
         (we && !is_writable(sel)) |=> $stable(regs_q);
   endproperty
   nonwritable_ignored_chk: assert property (p_nonwritable_ignored);

   // R9
   property p_no_we_no_change;
      @(posedge clk) disable iff (rst)
         !we |=> $stable(regs_q);
   endproperty
   no_we_no_change_chk: assert property (p_no_we_no_change);

endmodule

// File: rtl/rb_read_port.sv
module rb_read_port
   import rb_pkg::*;
#(
   parameter int unsigned       DATA_W    = 16,
   parameter logic [DATA_W-1:0] AMASK_VAL = 'h0FFF,
   parameter logic [DATA_W-1:0] SMASK_VAL = 'h00FF
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          ld,
   input  logic [SLOT_BITS-1:0]          sel,
   input  logic [NUM_WR-1:0][DATA_W-1:0] regs,
   output logic [DATA_W-1:0]             q
);

   logic [DATA_W-1:0] bus;

   always_comb begin
      unique case (slot_e'(sel))
         SL_PC, SL_AC, SL_SP, SL_IR, SL_TIR,
         SL_GA, SL_GB, SL_GC: bus = regs[wr_index(sel)];
         SL_ONE:              bus = DATA_W'(1);
         SL_MINUS:            bus = '1;
         SL_AMSK:             bus = AMASK_VAL;
         SL_SMSK:             bus = SMASK_VAL;
         default:             bus = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= bus;
   end

   // R6
   property p_hold_without_load;
      @(posedge clk) disable iff (rst)
         !ld |=> $stable(q);
   endproperty
   hold_without_load_chk: assert property (p_hold_without_load);

endmodule

// File: rtl/dual_read_regbank.sv
module dual_read_regbank
   import rb_pkg::*;
#(
   parameter int unsigned       DATA_W    = 16,
   parameter logic [DATA_W-1:0] AMASK_VAL = 'h0FFF,
   parameter logic [DATA_W-1:0] SMASK_VAL = 'h00FF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        a_sel,
   input  logic [3:0]        b_sel,
   input  logic              a_ld,
   input  logic              b_ld,
   input  logic [3:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   output logic [DATA_W-1:0] a_latch,
   output logic [DATA_W-1:0] b_latch
);

   localparam int unsigned NUM_PORTS = 2;

   if (DATA_W < 12) begin : g_bad_width
      $error("dual_read_regbank: DATA_W must hold the 12-bit address mask");
   end
   if (SLOT_BITS != 4) begin : g_bad_slots
      $error("dual_read_regbank: slot map requires a 4-bit address");
   end

   logic [NUM_WR-1:0][DATA_W-1:0]    regs_q;
   logic [NUM_PORTS-1:0][3:0]        p_sel;
   logic [NUM_PORTS-1:0]             p_ld;
   logic [NUM_PORTS-1:0][DATA_W-1:0] p_q;

   assign p_sel   = {b_sel, a_sel};
   assign p_ld    = {b_ld, a_ld};
   assign a_latch = p_q[0];
   assign b_latch = p_q[1];

   rb_store #(.DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en),
      .sel    (wr_sel),
      .din    (wr_data),
      .regs_q (regs_q)
   );

   for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      rb_read_port #(
         .DATA_W    (DATA_W),
         .AMASK_VAL (AMASK_VAL),
         .SMASK_VAL (SMASK_VAL)
      ) u_port (
         .clk  (clk),
         .rst  (rst),
         .ld   (p_ld[gp]),
         .sel  (p_sel[gp]),
         .regs (regs_q),
         .q    (p_q[gp])
      );
   end

   // R1
   property p_reset_clears;
      @(posedge clk) rst |=> (a_latch == '0 && b_latch == '0);
   endproperty
   reset_clears_chk: assert property (p_reset_clears);

   // R3
   property p_const_minus_one;
      @(posedge clk) disable iff (rst)
         (a_ld && a_sel == 4'd7) |=> (a_latch == '1);
   endproperty
   const_minus_one_chk: assert property (p_const_minus_one);

   // R3
   property p_const_amask;
      @(posedge clk) disable iff (rst)
         (b_ld && b_sel == 4'd8) |=> (b_latch == AMASK_VAL);
   endproperty
   const_amask_chk: assert property (p_const_amask);

   // R5
   property p_unused_zero;
      @(posedge clk) disable iff (rst)
         (a_ld && a_sel >= 4'd13) |=> (a_latch == '0);
   endproperty
   unused_zero_chk: assert property (p_unused_zero);

   // R8
   property p_same_slot_match;
      @(posedge clk) disable iff (rst)
         (a_ld && b_ld && a_sel == b_sel) |=> (a_latch == b_latch);
   endproperty
   same_slot_match_chk: assert property (p_same_slot_match);

endmodule

// File: tb/sim_dual_read_regbank.sv
`timescale 1ns/1ps
module sim_dual_read_regbank;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  a_sel = '0, b_sel = '0, wr_sel = '0;
   logic        a_ld = 1'b0, b_ld = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] a_latch, b_latch;

   always #10 clk = ~clk;

   dual_read_regbank u0 (
      .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel), .a_ld(a_ld), .b_ld(b_ld),
      .wr_sel(wr_sel), .wr_data(wr_data), .wr_en(wr_en),
      .a_latch(a_latch), .b_latch(b_latch)
   );

   typedef struct {
      string       tag;
      logic [15:0] a;
      logic [15:0] b;
   } item_t;

   item_t       sb[$];
   logic [15:0] ref_mem [16];
   logic [15:0] exp_a = '0, exp_b = '0;
   int          checks = 0, errors = 0;
   bit          done = 0;

   function automatic logic [15:0] ref_read(input logic [3:0] s);
      case (s)
         4'd5:  return 16'h0000;
         4'd6:  return 16'h0001;
         4'd7:  return 16'hFFFF;
         4'd8:  return 16'h0FFF;
         4'd9:  return 16'h00FF;
         4'd13, 4'd14, 4'd15: return 16'h0000;
         default: return ref_mem[s];
      endcase
   endfunction

   // driver: one clock edge of stimulus, expected latch values pushed afterwards
   task automatic step(input string tag, input logic r,
                       input logic al, input logic [3:0] as_,
                       input logic bl, input logic [3:0] bs_,
                       input logic we, input logic [3:0] ws, input logic [15:0] wd);
      item_t it;
      @(negedge clk);
      rst = r; a_ld = al; a_sel = as_; b_ld = bl; b_sel = bs_;
      wr_en = we; wr_sel = ws; wr_data = wd;
      if (r) begin
         exp_a = '0; exp_b = '0;
         for (int i = 0; i < 16; i++) ref_mem[i] = '0;
      end else begin
         if (al) exp_a = ref_read(as_);
         if (bl) exp_b = ref_read(bs_);
         if (we && (ws <= 4'd4 || (ws >= 4'd10 && ws <= 4'd12))) ref_mem[ws] = wd;
      end
      @(posedge clk);
      #1;
      it.tag = tag; it.a = exp_a; it.b = exp_b;
      sb.push_back(it);
   endtask

   // monitor: compares one expected item per cycle, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (a_latch !== it.a) begin
               errors++;
               $display("FAIL %s a_latch actual=%h expected=%h", it.tag, a_latch, it.a);
            end
            checks++;
            if (b_latch !== it.b) begin
               errors++;
               $display("FAIL %s b_latch actual=%h expected=%h", it.tag, b_latch, it.b);
            end
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] wslots [8];
      wslots = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd10, 4'd11, 4'd12};
      for (int i = 0; i < 16; i++) ref_mem[i] = '0;

      // R1: reset state
      step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R1", 1, 1, 4'd6, 1, 4'd7, 1, 4'd0, 16'hAAAA);
      step("R1 load after reset", 0, 1, 4'd0, 1, 4'd12, 0, 0, 0);

      // R2: write each writable slot, then read it back on both ports
      foreach (wslots[k]) step("R2 write", 0, 0, 0, 0, 0, 1, wslots[k], 16'h1100 + 16'(k * 16'h0111));
      foreach (wslots[k]) step("R2 read", 0, 1, wslots[k], 1, wslots[7 - k], 0, 0, 0);

      // R3: constants
      step("R3 zero/one", 0, 1, 4'd5, 1, 4'd6, 0, 0, 0);
      step("R3 minus/amask", 0, 1, 4'd7, 1, 4'd8, 0, 0, 0);
      step("R3 smask", 0, 1, 4'd9, 1, 4'd5, 0, 0, 0);

      // R4: writes to constant slots dropped, checked by immediate reload
      for (int s = 5; s <= 9; s++) begin
         step("R4 write", 0, 0, 0, 0, 0, 1, 4'(s), 16'h5A5A);
         step("R4 reload", 0, 1, 4'(s), 1, 4'(s), 0, 0, 0);
      end

      // R5: unused slots read zero, writes change nothing
      for (int s = 13; s <= 15; s++) begin
         step("R5 write", 0, 0, 0, 0, 0, 1, 4'(s), 16'hC3C3);
         step("R5 reload", 0, 1, 4'(s), 1, 4'(s), 0, 0, 0);
      end
      step("R5 others intact", 0, 1, 4'd1, 1, 4'd11, 0, 0, 0);

      // R6: hold without load strobe while selects move
      step("R6 prime", 0, 1, 4'd2, 1, 4'd3, 0, 0, 0);
      step("R6 hold", 0, 0, 4'd7, 0, 4'd9, 0, 0, 0);
      step("R6 hold a only", 0, 0, 4'd8, 1, 4'd6, 0, 0, 0);

      // R7: same-edge load and write returns the old value, the next load the new one
      step("R7 seed", 0, 0, 0, 0, 0, 1, 4'd10, 16'h1357);
      step("R7 same edge", 0, 1, 4'd10, 1, 4'd10, 1, 4'd10, 16'h2468);
      step("R7 next edge", 0, 1, 4'd10, 0, 4'd0, 0, 0, 0);

      // R8: both ports on one slot
      step("R8 same slot", 0, 1, 4'd4, 1, 4'd4, 0, 0, 0);
      step("R8 same const", 0, 1, 4'd8, 1, 4'd8, 0, 0, 0);

      // R9: write enable low leaves storage alone
      step("R9 no enable", 0, 0, 0, 0, 0, 0, 4'd0, 16'hDEAD);
      step("R9 reload", 0, 1, 4'd0, 1, 4'd0, 0, 0, 0);

      // R1: reset after activity clears registers again
      step("R1 again", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R1 regs cleared", 0, 1, 4'd0, 1, 4'd12, 0, 0, 0);

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule